// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Drain

This block holds stores between a core's in-order issue stage and one write port of the L1 data cache. Each store gets an entry when it issues, in program order, before it has executed. The entry's index goes back with the store. The store-address and store-data operations later fill the address half and the data half of that entry. Either half may arrive first. The core reports retirement by entry index. Only the oldest entry is offered to the cache, and only once it is fully filled and retired. Stores therefore become visible strictly in program order.

A full-fence request stalls new memory operations until every buffered store has reached the cache. The stall is exported to the issue stage. Store allocation is also refused while the fence is active or the queue is full, and the store that is refused simply waits at issue.

Top module: `ordered_store_queue`

## Requirements
- R1: After a synchronous reset the queue is empty: `cache_valid`, `issue_stall`, `mem_stall` and `retire_err` are low, and `alloc_idx` is 0.
- R2: Each accepted allocation (`alloc_valid` high while `issue_stall` is low) receives the index shown on `alloc_idx`. Successive allocations receive consecutive indices modulo DEPTH, wrapping from DEPTH-1 to 0.
- R3: With DEPTH entries occupied, `issue_stall` is high and an allocation request is not accepted: `alloc_idx` does not advance. The stall clears once an entry commits.
- R4: The address write and the data write fill separate halves of an entry, in either order. An entry is never offered to the cache until both halves are present, and it is offered with exactly the written address, data and byte enables.
- R5: An entry is not offered to the cache before its index has been retired, even if both halves are present.
- R6: Only the oldest entry is ever offered. A younger entry that is complete and retired waits behind an older one that is not. Each accepted commit removes exactly one entry.
- R7: `cache_valid` and its payload stay stable while `cache_ready` is low. The entry commits in a cycle where both are high.
- R8: A `fence_req` pulse with stores buffered raises `mem_stall` (and `issue_stall`) from the next cycle. Stores presented while the fence is active are not allocated.
- R9: `mem_stall` falls in the cycle right after the commit that empties the queue. It stays high while any entry remains. A fence requested on an empty queue raises no stall.
- R10: A retire naming an index that holds no store pulses `retire_err` high for one cycle, in the cycle after the request. Retiring an already-retired entry has no effect and flags no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A store is issuing and needs an entry |
| alloc_idx | output | log2(DEPTH) | Index granted to the issuing store |
| issue_stall | output | 1 | Allocation refused (queue full or fence active) |
| aw_valid | input | 1 | Store-address operation executes |
| aw_idx | input | log2(DEPTH) | Entry written by the address operation |
| aw_addr | input | ADDR_W | Store address |
| dw_valid | input | 1 | Store-data operation executes |
| dw_idx | input | log2(DEPTH) | Entry written by the data operation |
| dw_data | input | DATA_W | Store data |
| dw_be | input | DATA_W/8 | Byte-enable mask |
| rt_valid | input | 1 | A store retires |
| rt_idx | input | log2(DEPTH) | Entry of the retiring store |
| retire_err | output | 1 | Retire named an unallocated entry (one-cycle pulse) |
| cache_valid | output | 1 | Oldest entry offered to the cache |
| cache_ready | input | 1 | Cache accepts the write |
| cache_addr | output | ADDR_W | Address of the offered store |
| cache_data | output | DATA_W | Data of the offered store |
| cache_be | output | DATA_W/8 | Byte enables of the offered store |
| fence_req | input | 1 | Full-fence request pulse |
| mem_stall | output | 1 | New memory operations must wait (fence draining) |

## Verification
The hardest state to reach is a queue where younger entries are complete and retired while the head is still missing its retirement or one of its halves. From the ports, this is the only way to show that commit waits on the head rather than on any ready entry. The bench builds this state on purpose. It writes the data half of the head before its address half, fully prepares and retires two younger stores, and checks that nothing is offered until the head finally retires. A second hard case is the fence release edge. The bench holds the queue at two entries under a fence and then drains it. It checks that the stall holds after the first commit and is gone right after the second commit.

// File: rtl/osq_pkg.sv
package osq_pkg;
  // Entry status bits tracked beside the payload memory
  typedef struct packed {
    logic valid;
    logic addr_ok;
    logic data_ok;
    logic retired;
  } osq_flags_t;
endpackage

// File: rtl/osq_ptrs.sv
module osq_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  output logic [$clog2(DEPTH)-1:0]   head_idx,
  output logic [$clog2(DEPTH)-1:0]   tail_idx,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int IDX_W = $clog2(DEPTH);

  // one extra wrap bit on each pointer separates full from empty
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = tail_q - head_q;
  assign empty    = (tail_q == head_q);
  assign full     = (tail_q[IDX_W] != head_q[IDX_W]) &&
                    (tail_q[IDX_W-1:0] == head_q[IDX_W-1:0]);
endmodule

// File: rtl/osq_status.sv
module osq_status
  import osq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_en,
  input  logic [$clog2(DEPTH)-1:0]   alloc_at,
  input  logic                       aw_en,
  input  logic [$clog2(DEPTH)-1:0]   aw_at,
  input  logic                       dw_en,
  input  logic [$clog2(DEPTH)-1:0]   dw_at,
  input  logic                       rt_en,
  input  logic [$clog2(DEPTH)-1:0]   rt_at,
  input  logic                       free_en,
  input  logic [$clog2(DEPTH)-1:0]   free_at,
  output osq_flags_t                 flags [DEPTH],
  output logic                       bad_retire
);
  localparam int IDX_W = $clog2(DEPTH);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_entry
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
      osq_flags_t st;

      always_ff @(posedge clk) begin
        if (rst) begin
          st <= '0;
        end else if (free_en && free_at == MY_IDX) begin
          st <= '0;
        end else if (alloc_en && alloc_at == MY_IDX) begin
          st       <= '0;
          st.valid <= 1'b1;
        end else if (st.valid) begin
          if (aw_en && aw_at == MY_IDX) st.addr_ok <= 1'b1;
          if (dw_en && dw_at == MY_IDX) st.data_ok <= 1'b1;
          if (rt_en && rt_at == MY_IDX) st.retired <= 1'b1;
        end
      end

      assign flags[gi] = st;
    end
  endgenerate

  // retire aimed at an entry that holds no store
  always_ff @(posedge clk) begin
    if (rst) bad_retire <= 1'b0;
    else     bad_retire <= rt_en && !flags[rt_at].valid;
  end
endmodule

// File: rtl/osq_store_ram.sv
module osq_store_ram #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       aw_en,
  input  logic [$clog2(DEPTH)-1:0]   aw_at,
  input  logic [ADDR_W-1:0]          aw_addr,
  input  logic                       dw_en,
  input  logic [$clog2(DEPTH)-1:0]   dw_at,
  input  logic [DATA_W-1:0]          dw_data,
  input  logic [DATA_W/8-1:0]        dw_be,
  input  logic [$clog2(DEPTH)-1:0]   rd_at,
  output logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W/8-1:0]        rd_be
);
  localparam int BE_W = DATA_W / 8;

  // two independent write ports, no reset: maps onto distributed RAM
  logic [ADDR_W-1:0]      addr_mem [DEPTH];
  logic [DATA_W+BE_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (aw_en) addr_mem[aw_at] <= aw_addr;
  end

  always_ff @(posedge clk) begin
    if (dw_en) data_mem[dw_at] <= {dw_be, dw_data};
  end

  assign rd_addr = addr_mem[rd_at];
  assign {rd_be, rd_data} = data_mem[rd_at];
endmodule

// File: rtl/osq_fence.sv
module osq_fence (
  input  logic clk,
  input  logic rst,
  input  logic fence_req,
  input  logic empty_next,
  output logic active
);
  // clears on the same edge as the commit that empties the queue
  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= (active || fence_req) && !empty_next;
  end
endmodule

// File: rtl/ordered_store_queue.sv
module ordered_store_queue
  import osq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_valid,
  output logic [$clog2(DEPTH)-1:0]   alloc_idx,
  output logic                       issue_stall,
  input  logic                       aw_valid,
  input  logic [$clog2(DEPTH)-1:0]   aw_idx,
  input  logic [ADDR_W-1:0]          aw_addr,
  input  logic                       dw_valid,
  input  logic [$clog2(DEPTH)-1:0]   dw_idx,
  input  logic [DATA_W-1:0]          dw_data,
  input  logic [DATA_W/8-1:0]        dw_be,
  input  logic                       rt_valid,
  input  logic [$clog2(DEPTH)-1:0]   rt_idx,
  output logic                       retire_err,
  output logic                       cache_valid,
  input  logic                       cache_ready,
  output logic [ADDR_W-1:0]          cache_addr,
  output logic [DATA_W-1:0]          cache_data,
  output logic [DATA_W/8-1:0]        cache_be,
  input  logic                       fence_req,
  output logic                       mem_stall
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  initial begin
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("DEPTH must be a power of two of at least 2");
  end

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] count, count_next;
  logic             full, empty, fence_on;
  logic             push, pop;
  osq_flags_t       flags [DEPTH];
  osq_flags_t       head_st;

  assign issue_stall = full || fence_on;
  assign mem_stall   = fence_on;
  assign alloc_idx   = tail_idx;
  assign push        = alloc_valid && !issue_stall;

  assign head_st     = flags[head_idx];
  assign cache_valid = head_st.valid && head_st.addr_ok &&
                       head_st.data_ok && head_st.retired;
  assign pop         = cache_valid && cache_ready;

  assign count_next  = count + CNT_W'(push) - CNT_W'(pop);

  osq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .count    (count),
    .full     (full),
    .empty    (empty)
  );

  osq_status #(.DEPTH(DEPTH)) u_status (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (push),
    .alloc_at   (tail_idx),
    .aw_en      (aw_valid),
    .aw_at      (aw_idx),
    .dw_en      (dw_valid),
    .dw_at      (dw_idx),
    .rt_en      (rt_valid),
    .rt_at      (rt_idx),
    .free_en    (pop),
    .free_at    (head_idx),
    .flags      (flags),
    .bad_retire (retire_err)
  );

  osq_store_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .aw_en   (aw_valid),
    .aw_at   (aw_idx),
    .aw_addr (aw_addr),
    .dw_en   (dw_valid),
    .dw_at   (dw_idx),
    .dw_data (dw_data),
    .dw_be   (dw_be),
    .rd_at   (head_idx),
    .rd_addr (cache_addr),
    .rd_data (cache_data),
    .rd_be   (cache_be)
  );

  osq_fence u_fence (
    .clk        (clk),
    .rst        (rst),
    .fence_req  (fence_req),
    .empty_next (count_next == '0),
    .active     (fence_on)
  );
endmodule

// File: rtl/osq_checker.sv
module osq_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     alloc_valid,
  input logic [$clog2(DEPTH)-1:0] alloc_idx,
  input logic                     issue_stall,
  input logic                     mem_stall,
  input logic                     cache_valid,
  input logic                     cache_ready,
  input logic [ADDR_W-1:0]        cache_addr,
  input logic [DATA_W-1:0]        cache_data,
  input logic [$clog2(DEPTH):0]   count,
  input logic                     empty
);
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (count == DEPTH) && alloc_valid |=> $stable(alloc_idx)); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH); // R3
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    empty |-> !cache_valid); // R5
  AST_ONE_PER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    cache_valid && cache_ready && !(alloc_valid && !issue_stall)
      |=> count == $past(count) - 1'b1); // R6
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    cache_valid && !cache_ready
      |=> cache_valid && $stable(cache_addr) && $stable(cache_data)); // R7
  AST_FENCE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    mem_stall && alloc_valid |=> $stable(alloc_idx)); // R8
  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_stall) |-> empty); // R9
endmodule

bind ordered_store_queue osq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .alloc_idx   (alloc_idx),
  .issue_stall (issue_stall),
  .mem_stall   (mem_stall),
  .cache_valid (cache_valid),
  .cache_ready (cache_ready),
  .cache_addr  (cache_addr),
  .cache_data  (cache_data),
  .count       (count),
  .empty       (empty)
);

// File: tb/ordered_store_queue_test.sv
`timescale 1ns/1ps
module ordered_store_queue_test;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, aw_valid = 0, dw_valid = 0, rt_valid = 0;
  logic cache_ready = 0, fence_req = 0;
  logic [IW-1:0] aw_idx = '0, dw_idx = '0, rt_idx = '0;
  logic [AW-1:0] aw_addr = '0;
  logic [DW-1:0] dw_data = '0;
  logic [DW/8-1:0] dw_be = '0;
  logic [IW-1:0] alloc_idx;
  logic issue_stall, retire_err, cache_valid, mem_stall;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_data;
  logic [DW/8-1:0] cache_be;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ordered_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .issue_stall(issue_stall),
    .aw_valid(aw_valid), .aw_idx(aw_idx), .aw_addr(aw_addr),
    .dw_valid(dw_valid), .dw_idx(dw_idx), .dw_data(dw_data), .dw_be(dw_be),
    .rt_valid(rt_valid), .rt_idx(rt_idx), .retire_err(retire_err),
    .cache_valid(cache_valid), .cache_ready(cache_ready),
    .cache_addr(cache_addr), .cache_data(cache_data), .cache_be(cache_be),
    .fence_req(fence_req), .mem_stall(mem_stall)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_alloc(output logic [IW-1:0] idx);
    idx = alloc_idx;
    alloc_valid = 1'b1;
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic wr_addr(input logic [IW-1:0] idx, input logic [AW-1:0] a);
    aw_valid = 1'b1; aw_idx = idx; aw_addr = a;
    step();
    aw_valid = 1'b0;
  endtask

  task automatic wr_data(input logic [IW-1:0] idx, input logic [DW-1:0] d,
                         input logic [DW/8-1:0] be);
    dw_valid = 1'b1; dw_idx = idx; dw_data = d; dw_be = be;
    step();
    dw_valid = 1'b0;
  endtask

  task automatic retire(input logic [IW-1:0] idx);
    rt_valid = 1'b1; rt_idx = idx;
    step();
    rt_valid = 1'b0;
  endtask

  task automatic commit_expect(string req, logic [AW-1:0] a, logic [DW-1:0] d,
                               logic [DW/8-1:0] be);
    chk(req, cache_valid, 1);
    chk(req, cache_addr, a);
    chk(req, cache_data, d);
    chk(req, cache_be, be);
    cache_ready = 1'b1;
    step();
    cache_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cache_valid", cache_valid, 0);
    chk("R1 issue_stall", issue_stall, 0);
    chk("R1 mem_stall", mem_stall, 0);
    chk("R1 retire_err", retire_err, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
  endtask

  task automatic t_fill_and_order();
    logic [IW-1:0] i0, i1, i2, i3;
    do_alloc(i0); do_alloc(i1); do_alloc(i2);
    chk("R2 idx0", i0, 0); chk("R2 idx1", i1, 1); chk("R2 idx2", i2, 2);
    wr_data(i0, 32'hD000_0000, 4'hF);      // data half before address half
    wr_addr(i1, 32'hA000_0010);
    wr_data(i1, 32'hD000_0011, 4'h3);
    wr_addr(i2, 32'hA000_0020);
    wr_data(i2, 32'hD000_0022, 4'hC);
    wr_addr(i0, 32'hA000_0000);
    retire(i2); retire(i1);
    chk("R5 head not retired", cache_valid, 0);
    chk("R6 younger waits", cache_valid, 0);
    retire(i0);
    chk("R5 head retired", cache_valid, 1);
    step();
    chk("R7 held valid", cache_valid, 1);
    chk("R7 held addr", cache_addr, 32'hA000_0000);
    commit_expect("R4 entry0", 32'hA000_0000, 32'hD000_0000, 4'hF);
    commit_expect("R6 entry1", 32'hA000_0010, 32'hD000_0011, 4'h3);
    commit_expect("R6 entry2", 32'hA000_0020, 32'hD000_0022, 4'hC);
    chk("R6 drained", cache_valid, 0);
    do_alloc(i3);
    chk("R2 idx3", i3, 3);
    wr_addr(i3, 32'hA000_0030);
    retire(i3);
    chk("R4 data missing", cache_valid, 0);
    wr_data(i3, 32'hD000_0033, 4'h1);
    commit_expect("R4 entry3", 32'hA000_0030, 32'hD000_0033, 4'h1);
  endtask

  task automatic t_full();
    logic [IW-1:0] ids [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(ids[i]);
      chk("R2 wrap idx", ids[i], (4 + i) % DEPTH);
    end
    chk("R3 full stall", issue_stall, 1);
    alloc_valid = 1'b1;
    step();
    alloc_valid = 1'b0;
    chk("R3 refused", alloc_idx, 4);
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr(ids[i], 32'h100 + i);
      wr_data(ids[i], 32'h5500 + i, 4'hF);
      retire(ids[i]);
    end
    commit_expect("R6 full order", 32'h100, 32'h5500, 4'hF);
    chk("R3 stall cleared", issue_stall, 0);
    for (int i = 1; i < DEPTH; i++)
      commit_expect("R6 full order", 32'h100 + i, 32'h5500 + i, 4'hF);
    chk("R6 full drained", cache_valid, 0);
  endtask

  task automatic t_fence();
    logic [IW-1:0] a, b;
    do_alloc(a); do_alloc(b);
    wr_addr(a, 32'hF0); wr_data(a, 32'h1, 4'hF);
    wr_addr(b, 32'hF4); wr_data(b, 32'h2, 4'hF);
    fence_req = 1'b1;
    step();
    fence_req = 1'b0;
    chk("R8 mem_stall", mem_stall, 1);
    chk("R8 issue_stall", issue_stall, 1);
    alloc_valid = 1'b1;
    step();
    alloc_valid = 1'b0;
    chk("R8 store held", alloc_idx, 6);
    retire(a); retire(b);
    chk("R9 stall before drain", mem_stall, 1);
    commit_expect("R9 first", 32'hF0, 32'h1, 4'hF);
    chk("R9 stall one left", mem_stall, 1);
    commit_expect("R9 last", 32'hF4, 32'h2, 4'hF);
    chk("R9 released", mem_stall, 0);
    chk("R9 issue free", issue_stall, 0);
    fence_req = 1'b1;
    step();
    fence_req = 1'b0;
    chk("R9 fence on empty", mem_stall, 0);
  endtask

  task automatic t_retire_rules();
    logic [IW-1:0] e;
    retire(3'd2);
    chk("R10 bad retire", retire_err, 1);
    step();
    chk("R10 pulse ends", retire_err, 0);
    do_alloc(e);
    chk("R2 idx6", e, 6);
    wr_addr(e, 32'hBB); wr_data(e, 32'hCC, 4'h5);
    retire(e);
    chk("R10 good retire", retire_err, 0);
    retire(e);
    chk("R10 double retire", retire_err, 0);
    commit_expect("R10 single commit", 32'hBB, 32'hCC, 4'h5);
    chk("R10 no second commit", cache_valid, 0);
    retire(e);
    chk("R10 freed entry", retire_err, 1);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_fill_and_order();
    t_full();
    t_fence();
    t_retire_rules();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule